// File: doc/BRIEF.md
# DPI Pixel Input Conditioner

This block sits between a video encoder and the pixel (DPI) input of a display serial host. Every pixel clock it takes a data-enable, a horizontal sync and a vertical sync together with three colour components. It turns each sync into an active-high signal and zeroes the low bits the encoder does not drive. Any input component can be sent to any of the three output slots. When the output format is a subsampled YCbCr mode, one chroma pair is shared across each even/odd pixel pair.

The configuration arrives as static fields of a control word owned by the surrounding logic. The conditioned syncs and pixel data leave the block registered, exactly two clocks after they entered, in every mode. Downstream logic therefore never has to re-align syncs and data.

Top module: `px_dpi_conditioner`

## Requirements
- R1: While `rst_ni` is low, every output (`de_o`, `hs_o`, `vs_o`, `slot0_o`, `slot1_o`, `slot2_o`) is 0.
- R2: Each output reflects the input sampled exactly two rising clock edges earlier. Syncs and pixel data stay aligned in every configuration.
- R3: Each sync has its own invert bit (`cfg_inv_de_i`, `cfg_inv_hs_i`, `cfg_inv_vs_i`). When the bit is 1 the output is the complement of the input. When it is 0 the input passes unchanged.
- R4: Output slot s carries input component `cfg_sel<s>_i`, where code 0 selects `comp0_i`, 1 selects `comp1_i` and 2 selects `comp2_i`. The reserved code 3 selects `comp0_i`.
- R5: Width code `cfg_in_width_i` keeps only the top bits of each input component, before routing, and clears the rest. The number of bits kept depends on the code:
  - 0 keeps 10 bits.
  - 1 keeps 8 bits.
  - 2 keeps 6 bits.
  - 3 keeps 5, 6 and 5 bits of components 0, 1 and 2.
  - Codes 4 to 7 keep all bits.
- R6: Chroma sharing applies only when `cfg_out_fmt_i` is 6, 7, 8 or 11. Every other format, including codes 12 to 15, passes slots 1 and 2 through unchanged.
- R7: Parity is counted among the active pixels (DE high after inversion). The first active pixel after DE rises is even, and parity alternates on each following active pixel.
- R8: With chroma policy 0 (`cfg_chroma_mode_i`), both pixels of an even/odd pair carry the even pixel's slot 1 and slot 2 values. Policy 3 behaves like policy 0.
- R9: With chroma policy 1, both pixels of a pair carry the odd pixel's slot 1 and slot 2 values.
- R10: With chroma policy 2, both pixels of a pair carry the rounded-up average (even + odd + 1) >> 1, computed separately for slot 1 and slot 2.
- R11: An even pixel with no odd partner, because DE falls after it, keeps its own chroma. Pixels outside DE are never altered.
- R12: Slot 0 is never affected by chroma sharing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_inv_de_i | input | 1 | Invert data-enable input |
| cfg_inv_hs_i | input | 1 | Invert horizontal sync input |
| cfg_inv_vs_i | input | 1 | Invert vertical sync input |
| cfg_sel0_i | input | 2 | Source component for slot 0 |
| cfg_sel1_i | input | 2 | Source component for slot 1 |
| cfg_sel2_i | input | 2 | Source component for slot 2 |
| cfg_chroma_mode_i | input | 2 | Pair chroma policy: even, odd, average |
| cfg_in_width_i | input | 3 | Valid input width code |
| cfg_out_fmt_i | input | 4 | Output pixel format code |
| de_i | input | 1 | Data enable from encoder |
| hs_i | input | 1 | Horizontal sync from encoder |
| vs_i | input | 1 | Vertical sync from encoder |
| comp0_i | input | CW | Input component 0 |
| comp1_i | input | CW | Input component 1 |
| comp2_i | input | CW | Input component 2 |
| de_o | output | 1 | Conditioned active-high data enable |
| hs_o | output | 1 | Conditioned active-high horizontal sync |
| vs_o | output | 1 | Conditioned active-high vertical sync |
| slot0_o | output | CW | Output slot 0 (Y or R) |
| slot1_o | output | CW | Output slot 1 (Cb or G) |
| slot2_o | output | CW | Output slot 2 (Cr or B) |

## Verification
The pair-equality and parity properties assume that the format and chroma policy do not change while a pair is in flight. The latency properties assume that inputs are known from the first edge after reset. The stimulus changes configuration only while DE is inactive, then runs idle cycles before the next burst. During those idle cycles the syncs sit at their inactive level for the current polarity. Lines are built from runs of active pixels separated by gaps, so the DE-rise parity restart and lone trailing pixels both occur.

// File: rtl/px_dpi_pkg.sv
package px_dpi_pkg;

    localparam int NUM_COMP   = 3;
    localparam int NUM_CHROMA = 2;

    localparam logic [1:0] CHR_EVEN = 2'd0;
    localparam logic [1:0] CHR_ODD  = 2'd1;
    localparam logic [1:0] CHR_AVG  = 2'd2;

    localparam logic [2:0] INW_30 = 3'd0;
    localparam logic [2:0] INW_24 = 3'd1;
    localparam logic [2:0] INW_18 = 3'd2;
    localparam logic [2:0] INW_16 = 3'd3;

    localparam logic [3:0] FMT_YCC422_20 = 4'd6;
    localparam logic [3:0] FMT_YCC422_24 = 4'd7;
    localparam logic [3:0] FMT_YCC422_16 = 4'd8;
    localparam logic [3:0] FMT_YCC420_12 = 4'd11;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } sync_t;

    // True for the subsampled YCbCr output codes
    function automatic logic fmt_shares_chroma(input logic [3:0] fmt);
        return (fmt == FMT_YCC422_20) || (fmt == FMT_YCC422_24) ||
               (fmt == FMT_YCC422_16) || (fmt == FMT_YCC420_12);
    endfunction

    // Number of MSBs kept for component idx under a width code
    function automatic int width_keep_bits(input logic [2:0] code, input int idx);
        case (code)
            INW_30:  return 10;
            INW_24:  return 8;
            INW_18:  return 6;
            INW_16:  return (idx == 1) ? 6 : 5;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/px_width_mask.sv
module px_width_mask
    import px_dpi_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [2:0]                   code_i,
    input  logic [NUM_COMP-1:0][CW-1:0]  comp_i,
    output logic [NUM_COMP-1:0][CW-1:0]  comp_o
);

    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
        logic [CW-1:0] keep_mask;
        int            keep_bits;

        always_comb begin
            keep_bits = width_keep_bits(code_i, k);
            for (int b = 0; b < CW; b++) begin
                keep_mask[b] = (b >= CW - keep_bits);
            end
        end

        assign comp_o[k] = comp_i[k] & keep_mask;
    end

endmodule

// File: rtl/px_component_xbar.sv
module px_component_xbar
    import px_dpi_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [NUM_COMP-1:0][1:0]     sel_i,
    input  logic [NUM_COMP-1:0][CW-1:0]  comp_i,
    output logic [NUM_COMP-1:0][CW-1:0]  slot_o
);

    for (genvar s = 0; s < NUM_COMP; s++) begin : g_slot
        always_comb begin
            case (sel_i[s])
                2'd1:    slot_o[s] = comp_i[1];
                2'd2:    slot_o[s] = comp_i[2];
                default: slot_o[s] = comp_i[0];
            endcase
        end
    end

endmodule

// File: rtl/px_chroma_pair.sv
module px_chroma_pair
    import px_dpi_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [1:0]                     mode_i,
    input  logic [NUM_CHROMA-1:0][CW-1:0]  even_i,
    input  logic [NUM_CHROMA-1:0][CW-1:0]  odd_i,
    output logic [NUM_CHROMA-1:0][CW-1:0]  pair_o
);

    for (genvar k = 0; k < NUM_CHROMA; k++) begin : g_chroma
        logic [CW:0] sum;

        assign sum = {1'b0, even_i[k]} + {1'b0, odd_i[k]} + {{CW{1'b0}}, 1'b1};

        always_comb begin
            case (mode_i)
                CHR_ODD: pair_o[k] = odd_i[k];
                CHR_AVG: pair_o[k] = sum[CW:1];
                default: pair_o[k] = even_i[k];
            endcase
        end
    end

endmodule

// File: rtl/px_dpi_conditioner.sv
module px_dpi_conditioner
    import px_dpi_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_inv_de_i,
    input  logic          cfg_inv_hs_i,
    input  logic          cfg_inv_vs_i,
    input  logic [1:0]    cfg_sel0_i,
    input  logic [1:0]    cfg_sel1_i,
    input  logic [1:0]    cfg_sel2_i,
    input  logic [1:0]    cfg_chroma_mode_i,
    input  logic [2:0]    cfg_in_width_i,
    input  logic [3:0]    cfg_out_fmt_i,
    input  logic          de_i,
    input  logic          hs_i,
    input  logic          vs_i,
    input  logic [CW-1:0] comp0_i,
    input  logic [CW-1:0] comp1_i,
    input  logic [CW-1:0] comp2_i,
    output logic          de_o,
    output logic          hs_o,
    output logic          vs_o,
    output logic [CW-1:0] slot0_o,
    output logic [CW-1:0] slot1_o,
    output logic [CW-1:0] slot2_o
);

    typedef struct packed {
        sync_t                       sync;
        logic                        par;
        logic [NUM_COMP-1:0][CW-1:0] px;
    } stage_t;

    typedef struct packed {
        stage_t                        s1;
        stage_t                        s2;
        logic [NUM_CHROMA-1:0][CW-1:0] held;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_COMP-1:0][CW-1:0]   comp_in;
    logic [NUM_COMP-1:0][CW-1:0]   comp_masked;
    logic [NUM_COMP-1:0][CW-1:0]   comp_routed;
    logic [NUM_COMP-1:0][1:0]      sel;
    logic [NUM_CHROMA-1:0][CW-1:0] even_chroma;
    logic [NUM_CHROMA-1:0][CW-1:0] odd_chroma;
    logic [NUM_CHROMA-1:0][CW-1:0] pair_chroma;
    logic                          share_en;
    logic                          out_par;

    assign comp_in = {comp2_i, comp1_i, comp0_i};
    assign sel     = {cfg_sel2_i, cfg_sel1_i, cfg_sel0_i};

    px_width_mask #(.CW(CW)) i_mask (
        .code_i (cfg_in_width_i),
        .comp_i (comp_in),
        .comp_o (comp_masked)
    );

    px_component_xbar #(.CW(CW)) i_xbar (
        .sel_i  (sel),
        .comp_i (comp_masked),
        .slot_o (comp_routed)
    );

    // Chroma slots are 1 and 2; the even pixel sits in stage 1, its partner at the input
    assign even_chroma = {st_q.s1.px[2], st_q.s1.px[1]};
    assign odd_chroma  = {comp_routed[2], comp_routed[1]};

    px_chroma_pair #(.CW(CW)) i_pair (
        .mode_i (cfg_chroma_mode_i),
        .even_i (even_chroma),
        .odd_i  (odd_chroma),
        .pair_o (pair_chroma)
    );

    assign share_en = fmt_shares_chroma(cfg_out_fmt_i);

    always_comb begin
        st_d = st_q;

        // Stage 1: polarity, masking, routing, parity
        st_d.s1.sync.de = de_i ^ cfg_inv_de_i;
        st_d.s1.sync.hs = hs_i ^ cfg_inv_hs_i;
        st_d.s1.sync.vs = vs_i ^ cfg_inv_vs_i;
        st_d.s1.par     = st_d.s1.sync.de & st_q.s1.sync.de & ~st_q.s1.par;
        st_d.s1.px      = comp_routed;

        // Stage 2: pair-wise chroma sharing
        st_d.s2 = st_q.s1;
        if (share_en && st_q.s1.sync.de) begin
            if (st_q.s1.par) begin
                st_d.s2.px[1] = st_q.held[0];
                st_d.s2.px[2] = st_q.held[1];
            end else if (st_d.s1.par) begin
                st_d.s2.px[1] = pair_chroma[0];
                st_d.s2.px[2] = pair_chroma[1];
                st_d.held     = pair_chroma;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign de_o    = st_q.s2.sync.de;
    assign hs_o    = st_q.s2.sync.hs;
    assign vs_o    = st_q.s2.sync.vs;
    assign slot0_o = st_q.s2.px[0];
    assign slot1_o = st_q.s2.px[1];
    assign slot2_o = st_q.s2.px[2];
    assign out_par = st_q.s2.par;

endmodule

// File: rtl/px_dpi_conditioner_chk.sv
module px_dpi_conditioner_chk #(
    parameter int CW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cfg_inv_de_i,
    input logic          cfg_inv_hs_i,
    input logic          cfg_inv_vs_i,
    input logic [3:0]    cfg_out_fmt_i,
    input logic          de_i,
    input logic          hs_i,
    input logic          vs_i,
    input logic          de_o,
    input logic          hs_o,
    input logic          vs_o,
    input logic [CW-1:0] slot0_o,
    input logic [CW-1:0] slot1_o,
    input logic [CW-1:0] slot2_o,
    input logic          out_par_i
);

    logic [1:0] warm;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (!de_o && !hs_o && !vs_o &&
                            slot0_o == '0 && slot1_o == '0 && slot2_o == '0));

    assert_de_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm >= 2'd2) |-> (de_o == $past(de_i ^ cfg_inv_de_i, 2)));

    assert_sync_polarity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm >= 2'd2) |-> (hs_o == $past(hs_i ^ cfg_inv_hs_i, 2) &&
                            vs_o == $past(vs_i ^ cfg_inv_vs_i, 2)));

    assert_first_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm >= 2'd2 && de_o && !$past(de_o)) |-> !out_par_i);

    assert_odd_follows_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm >= 2'd2 && out_par_i) |-> ($past(de_o) && !$past(out_par_i)));

    assert_pair_shared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm >= 2'd2 && out_par_i && px_dpi_pkg::fmt_shares_chroma(cfg_out_fmt_i) &&
         $stable(cfg_out_fmt_i))
        |-> (slot1_o == $past(slot1_o) && slot2_o == $past(slot2_o)));

endmodule

bind px_dpi_conditioner px_dpi_conditioner_chk #(.CW(CW)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_inv_de_i  (cfg_inv_de_i),
    .cfg_inv_hs_i  (cfg_inv_hs_i),
    .cfg_inv_vs_i  (cfg_inv_vs_i),
    .cfg_out_fmt_i (cfg_out_fmt_i),
    .de_i          (de_i),
    .hs_i          (hs_i),
    .vs_i          (vs_i),
    .de_o          (de_o),
    .hs_o          (hs_o),
    .vs_o          (vs_o),
    .slot0_o       (slot0_o),
    .slot1_o       (slot1_o),
    .slot2_o       (slot2_o),
    .out_par_i     (out_par)
);

// File: tb/test_px_dpi_conditioner.sv
module test_px_dpi_conditioner;

    localparam int CW   = 12;
    localparam int MAXN = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_de = 0, inv_hs = 0, inv_vs = 0;
    logic [1:0]    sel0 = 0, sel1 = 1, sel2 = 2;
    logic [1:0]    cmode = 0;
    logic [2:0]    inw = 3'd7;
    logic [3:0]    fmt = 4'd5;
    logic          de = 0, hs = 0, vs = 0;
    logic [CW-1:0] c0 = 0, c1 = 0, c2 = 0;
    logic          de_o, hs_o, vs_o;
    logic [CW-1:0] s0_o, s1_o, s2_o;

    int checks = 0;
    int errors = 0;

    logic          st_de [MAXN], st_hs [MAXN], st_vs [MAXN];
    logic [CW-1:0] st_c0 [MAXN], st_c1 [MAXN], st_c2 [MAXN];
    logic          ex_de [MAXN], ex_hs [MAXN], ex_vs [MAXN];
    logic [CW-1:0] ex_s0 [MAXN], ex_s1 [MAXN], ex_s2 [MAXN];
    int            n = 0;

    px_dpi_conditioner #(.CW(CW)) i_px_dpi_conditioner (
        .clk_i (clk), .rst_ni (rst_n),
        .cfg_inv_de_i (inv_de), .cfg_inv_hs_i (inv_hs), .cfg_inv_vs_i (inv_vs),
        .cfg_sel0_i (sel0), .cfg_sel1_i (sel1), .cfg_sel2_i (sel2),
        .cfg_chroma_mode_i (cmode), .cfg_in_width_i (inw), .cfg_out_fmt_i (fmt),
        .de_i (de), .hs_i (hs), .vs_i (vs),
        .comp0_i (c0), .comp1_i (c1), .comp2_i (c2),
        .de_o (de_o), .hs_o (hs_o), .vs_o (vs_o),
        .slot0_o (s0_o), .slot1_o (s1_o), .slot2_o (s2_o)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Bits kept per width code (R5)
    function automatic logic [CW-1:0] keep_mask(int code, int k);
        int kb;
        case (code)
            0: kb = 10;
            1: kb = 8;
            2: kb = 6;
            3: kb = (k == 1) ? 6 : 5;
            default: kb = CW;
        endcase
        return {CW{1'b1}} << (CW - kb);
    endfunction

    function automatic logic [CW-1:0] pick(logic [1:0] s, logic [CW-1:0] a,
                                           logic [CW-1:0] b, logic [CW-1:0] c);
        if (s == 2'd1) return b;
        if (s == 2'd2) return c;
        return a;
    endfunction

    function automatic logic [CW-1:0] combine(logic [CW-1:0] e, logic [CW-1:0] o);
        if (cmode == 2'd1) return o;
        if (cmode == 2'd2) return CW'((int'(e) + int'(o) + 1) / 2);
        return e;
    endfunction

    task automatic build_expect();
        logic          cde [MAXN];
        logic [CW-1:0] r0 [MAXN], r1 [MAXN], r2 [MAXN];
        int            pos [MAXN];
        logic          ycc;
        ycc = (fmt == 4'd6) || (fmt == 4'd7) || (fmt == 4'd8) || (fmt == 4'd11);
        for (int c = 0; c < n; c++) begin
            logic [CW-1:0] m0, m1, m2;
            cde[c]   = st_de[c] ^ inv_de;
            ex_de[c] = cde[c];
            ex_hs[c] = st_hs[c] ^ inv_hs;
            ex_vs[c] = st_vs[c] ^ inv_vs;
            m0 = st_c0[c] & keep_mask(int'(inw), 0);
            m1 = st_c1[c] & keep_mask(int'(inw), 1);
            m2 = st_c2[c] & keep_mask(int'(inw), 2);
            r0[c] = pick(sel0, m0, m1, m2);
            r1[c] = pick(sel1, m0, m1, m2);
            r2[c] = pick(sel2, m0, m1, m2);
            pos[c] = (cde[c] && c > 0 && cde[c-1]) ? pos[c-1] + 1 : 0;
        end
        for (int c = 0; c < n; c++) begin
            ex_s0[c] = r0[c];
            ex_s1[c] = r1[c];
            ex_s2[c] = r2[c];
            if (ycc && cde[c]) begin
                if (pos[c] % 2 == 1) begin
                    ex_s1[c] = combine(r1[c-1], r1[c]);
                    ex_s2[c] = combine(r2[c-1], r2[c]);
                end else if (c + 1 < n && cde[c+1]) begin
                    ex_s1[c] = combine(r1[c], r1[c+1]);
                    ex_s2[c] = combine(r2[c], r2[c+1]);
                end
            end
        end
    endtask

    // Fill stimulus: active runs of run_len separated by 2 idle cycles
    task automatic fill(int len, int run_len, int seed);
        n = len;
        for (int i = 0; i < len; i++) begin
            int ph;
            ph = i % (run_len + 2);
            st_de[i] = ((ph >= 1) && (ph <= run_len)) ^ inv_de;
            st_hs[i] = (ph == run_len + 1) ^ inv_hs;
            st_vs[i] = (i < 2) ^ inv_vs;
            st_c0[i] = CW'(seed * 7 + i * 291 + 17);
            st_c1[i] = CW'(seed * 13 + i * 613 + 901);
            st_c2[i] = CW'(4000 - seed * 5 - i * 377);
        end
    endtask

    task automatic drive_idle();
        de = inv_de; hs = inv_hs; vs = inv_vs;
        c0 = '0; c1 = '0; c2 = '0;
    endtask

    task automatic idle_cycles(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            drive_idle();
        end
    endtask

    task automatic play(string tag);
        build_expect();
        for (int c = 0; c < n + 2; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                int e;
                e = c - 2;
                checks++;
                if (de_o !== ex_de[e] || hs_o !== ex_hs[e] || vs_o !== ex_vs[e] ||
                    s0_o !== ex_s0[e] || s1_o !== ex_s1[e] || s2_o !== ex_s2[e]) begin
                    errors++;
                    $display("FAIL %s pixel %0d: got de=%b hs=%b vs=%b %h %h %h expected de=%b hs=%b vs=%b %h %h %h",
                             tag, e, de_o, hs_o, vs_o, s0_o, s1_o, s2_o,
                             ex_de[e], ex_hs[e], ex_vs[e], ex_s0[e], ex_s1[e], ex_s2[e]);
                end
            end
            if (c < n) begin
                de = st_de[c]; hs = st_hs[c]; vs = st_vs[c];
                c0 = st_c0[c]; c1 = st_c1[c]; c2 = st_c2[c];
            end else begin
                drive_idle();
            end
        end
        idle_cycles(2);
    endtask

    task automatic configure(logic idn, logic ihs, logic ivs, logic [1:0] a, logic [1:0] b,
                             logic [1:0] c, logic [1:0] m, logic [2:0] w, logic [3:0] f);
        @(negedge clk);
        inv_de = idn; inv_hs = ihs; inv_vs = ivs;
        sel0 = a; sel1 = b; sel2 = c; cmode = m; inw = w; fmt = f;
        drive_idle();
        idle_cycles(3);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        de = 1; hs = 1; vs = 1; c0 = '1; c1 = '1; c2 = '1;
        repeat (3) @(negedge clk);
        checks++;
        if (de_o !== 0 || hs_o !== 0 || vs_o !== 0 || s0_o !== 0 || s1_o !== 0 || s2_o !== 0) begin
            errors++;
            $display("FAIL R1 reset: got de=%b hs=%b vs=%b %h %h %h expected all 0",
                     de_o, hs_o, vs_o, s0_o, s1_o, s2_o);
        end
        drive_idle();
        rst_n = 1'b1;
        idle_cycles(3);
    endtask

    task automatic t_latency_r2();
        configure(0, 0, 0, 0, 1, 2, 0, 3'd7, 4'd5);
        fill(16, 4, 1);
        play("R2 latency");
    endtask

    task automatic t_polarity_r3();
        configure(1, 1, 1, 0, 1, 2, 0, 3'd7, 4'd5);
        fill(16, 4, 2);
        play("R3 all inverted");
        configure(0, 1, 0, 0, 1, 2, 0, 3'd7, 4'd5);
        fill(12, 3, 3);
        play("R3 hs inverted");
    endtask

    task automatic t_xbar_r4();
        configure(0, 0, 0, 2, 0, 1, 0, 3'd7, 4'd5);
        fill(12, 4, 4);
        play("R4 rotate");
        configure(0, 0, 0, 3, 3, 1, 0, 3'd7, 4'd5);
        fill(12, 4, 5);
        play("R4 reserved code");
    endtask

    task automatic t_width_r5();
        configure(0, 0, 0, 0, 1, 2, 0, 3'd0, 4'd5);
        fill(10, 4, 6);
        play("R5 code0");
        configure(0, 0, 0, 0, 1, 2, 0, 3'd1, 4'd5);
        fill(10, 4, 7);
        play("R5 code1");
        configure(0, 0, 0, 0, 1, 2, 0, 3'd2, 4'd5);
        fill(10, 4, 8);
        play("R5 code2");
        configure(0, 0, 0, 2, 1, 0, 0, 3'd3, 4'd5);
        fill(10, 4, 9);
        play("R5 code3 routed");
        configure(0, 0, 0, 0, 1, 2, 0, 3'd5, 4'd5);
        fill(10, 4, 10);
        play("R5 code5 full");
    endtask

    task automatic t_noshare_r6();
        configure(0, 0, 0, 0, 1, 2, 2, 3'd7, 4'd5);
        fill(12, 4, 11);
        play("R6 rgb888");
        configure(0, 0, 0, 0, 1, 2, 2, 3'd7, 4'd12);
        fill(12, 4, 12);
        play("R6 code12");
        configure(0, 0, 0, 0, 1, 2, 1, 3'd7, 4'd9);
        fill(12, 4, 13);
        play("R6 code9");
    endtask

    task automatic t_even_r8();
        configure(0, 0, 0, 0, 1, 2, 0, 3'd7, 4'd6);
        fill(18, 4, 14);
        play("R8 R7 even policy");
        configure(0, 0, 0, 0, 1, 2, 3, 3'd7, 4'd8);
        fill(18, 4, 15);
        play("R8 policy3");
    endtask

    task automatic t_odd_r9();
        configure(0, 0, 0, 0, 1, 2, 1, 3'd7, 4'd7);
        fill(18, 4, 16);
        play("R9 odd policy");
    endtask

    task automatic t_avg_r10();
        configure(0, 0, 0, 1, 2, 0, 2, 3'd7, 4'd11);
        fill(18, 4, 17);
        st_c2[1] = 12'd5;  st_c2[2] = 12'd6;
        st_c0[1] = 12'd9;  st_c0[2] = 12'd10;
        play("R10 R12 average");
    endtask

    task automatic t_lone_r11();
        configure(0, 0, 0, 0, 1, 2, 2, 3'd7, 4'd6);
        fill(20, 3, 18);
        play("R11 R7 odd-length lines");
        configure(1, 0, 0, 0, 1, 2, 1, 3'd7, 4'd7);
        fill(15, 1, 19);
        play("R11 single pixels");
    endtask

    initial begin
        drive_idle();
        t_reset_r1();
        t_latency_r2();
        t_polarity_r3();
        t_xbar_r4();
        t_width_r5();
        t_noshare_r6();
        t_even_r8();
        t_odd_r9();
        t_avg_r10();
        t_lone_r11();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule